// File: doc/BRIEF.md
# Stereo Audio Serial Data Port

This block moves audio samples between a host serial port and a stereo converter pair. The host supplies a bit clock, a word/frame clock and an inbound data line. The block returns an outbound data line and presents each received word on a parallel register with a one-cycle valid strobe. Outbound words come from parallel inputs: the status word and the left and right ADC samples. The bit clock and word clock are sampled by the block's system clock, which must run at least four times faster than the bit clock. Every pin edge is found by comparing the pin with its value on the previous system clock.

After reset the port is in DSP mode. A frame-sync level on the word clock starts a frame of three fixed-length slots. The inbound slots carry a control word, then the left DAC word, then the right DAC word. The outbound slots carry the status word, then the left ADC word, then the right ADC word. The leading bits of each control word can select a new word width, or switch the port to I2S mode. In I2S mode the word-clock level picks the channel and a word-clock change closes the current word. One serial port can therefore configure the device and stream its audio.

Top module: `audio_serial_port`

## Requirements
- R1: After reset the port is in DSP mode (cfgI2s = 0) with width code 00. sdOut, rxValid and rxWord are all zero.
- R2: In DSP mode, wordClk high at a bit-clock rise is a frame sync. The next 3*SLOT_BITS bits form three slots of SLOT_BITS bits each: control (rxSlot = 0), then left (rxSlot = 1), then right (rxSlot = 2). Each word occupies the leading W bits of its slot, MSB first.
- R3: In DSP mode the outbound slots carry, in order, the low W bits of statusIn, adcLeftIn and adcRightIn, MSB first. Each value is captured when its slot begins.
- R4: For bit positions W and above within a slot, sdOut is driven 0 and sdIn is ignored.
- R5: rxValid pulses for exactly one system clock, one clock after the edge that sees the bit-clock rise of a word's last bit (position W-1). rxWord then holds the W received bits right-aligned with zeros above them. rxSlot names the slot. Both hold until the next delivery.
- R6: The width code sets W: 00 = 16, 01 = 18, 10 = 20, 11 = 24 bits.
- R7: The first three bits of a received control word set the pending configuration. The first bit set to 1 selects I2S; the next two bits are the width code, MSB first. The pending configuration takes effect at the next frame-sync rise, where cfgI2s and cfgWidth change. I2S mode then holds until reset, and the port stays idle until the word clock next changes.
- R8: In I2S mode, wordClk low selects left (rxSlot = 1, adcLeftIn) and high selects right (rxSlot = 2, adcRightIn). A rise that sees wordClk differ from its value at the previous rise samples the last bit of the old word. The new word's MSB is driven on the following fall. A word shorter than W delivers nothing.
- R9: sdOut changes only on the system-clock edge where bitClk is first seen low. sdIn is read only on the edge where bitClk is first seen high.
- R10: After the right slot of a DSP frame the port is idle. sdOut stays 0 and nothing is delivered until the next frame sync.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the bit clock |
| rst | input | 1 | Synchronous active-high reset |
| bitClk | input | 1 | Serial bit clock from the host |
| wordClk | input | 1 | Frame sync (DSP mode) or channel select (I2S mode) |
| sdIn | input | 1 | Inbound serial data (control and DAC words) |
| sdOut | output | 1 | Outbound serial data (status and ADC words) |
| statusIn | input | MAX_W | Status word sent in the first DSP slot |
| adcLeftIn | input | MAX_W | Left ADC sample to send |
| adcRightIn | input | MAX_W | Right ADC sample to send |
| rxWord | output | MAX_W | Last received word, right-aligned |
| rxValid | output | 1 | One-cycle strobe for a new rxWord |
| rxSlot | output | 2 | Slot of rxWord: 0 control, 1 left, 2 right |
| cfgI2s | output | 1 | 1 when I2S mode is in force |
| cfgWidth | output | 2 | Width code in force |

## Verification
An outbound bit is due on sdOut one system clock after the bench drives the bit-clock fall. A delivered word shows on rxValid, rxWord and rxSlot one clock after the bench drives the rise of that word's last bit. A configuration change shows one clock after the frame-sync rise. The bench drives every pin on the falling system-clock edge and steps a behavioural model at the same moment. It compares all outputs with the model on the next falling edge, half a period after the registers change. A bit period spans four system clocks, so the bench can observe each of these latencies separately.

// File: rtl/audio_port_pkg.sv
package audio_port_pkg;

  // Slot identity; DSP order is ctrl, left, right, and right+1 is idle.
  typedef enum logic [1:0] {
    SLOT_CTRL  = 2'd0,
    SLOT_LEFT  = 2'd1,
    SLOT_RIGHT = 2'd2,
    SLOT_IDLE  = 2'd3
  } slot_e;

  // Strobes from the sequencer to the shift datapath.
  typedef struct packed {
    logic       sample;   // bit-clock rise inside the word: shift sdIn in
    logic       deliver;  // the sampled bit completes the word
    slot_e      rxSlot;   // slot of the word being completed
    logic       load;     // a new slot begins: load tx word, clear rx
    slot_e      txSlot;   // slot that begins
    logic [1:0] txWc;     // width code in force for that slot
    logic       launch;   // bit-clock fall: drive next outbound bit
    logic       active;   // the bit in flight lies inside the word
  } strobe_t;

  function automatic int unsigned widthOf(input logic [1:0] code);
    case (code)
      2'd0:    return 16;
      2'd1:    return 18;
      2'd2:    return 20;
      default: return 24;
    endcase
  endfunction

endpackage

// File: rtl/audio_port_ctrl.sv
module audio_port_ctrl
  import audio_port_pkg::*;
#(
  parameter int SLOT_BITS = 32
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       bitClk,
  input  logic       wordClk,
  input  logic       sdIn,
  output strobe_t    strb,
  output logic       cfgI2s,
  output logic [1:0] cfgWc
);
  localparam int CW = $clog2(SLOT_BITS);
  localparam logic [CW-1:0] LAST_BIT = CW'(SLOT_BITS - 1);

  logic          bitClkQ, wsPrev, pendValid;
  logic [2:0]    head, pend;
  logic [CW-1:0] bitIdx, nxtBit;
  slot_e         slot, nxtSlot, startSlot;
  logic          rise, fall, inWord, lastOfWord;
  logic          restart, dspWrap, commit, doLoad;
  logic [1:0]    newWc;
  int unsigned   curW;

  assign rise       = bitClk & ~bitClkQ;
  assign fall       = ~bitClk & bitClkQ;
  assign curW       = widthOf(cfgWc);
  assign inWord     = (slot != SLOT_IDLE) && (32'(bitIdx) < curW);
  assign lastOfWord = inWord && (32'(bitIdx) == curW - 1);

  // A slot sequence restarts on frame sync (DSP) or on a word-clock change (I2S).
  assign restart   = cfgI2s ? (wordClk != wsPrev) : wordClk;
  assign startSlot = !cfgI2s ? SLOT_CTRL : (wordClk ? SLOT_RIGHT : SLOT_LEFT);
  assign dspWrap   = !cfgI2s && (slot != SLOT_IDLE) && (bitIdx == LAST_BIT);
  assign commit    = rise && !cfgI2s && wordClk && pendValid;
  assign newWc     = commit ? pend[1:0] : cfgWc;

  always_comb begin
    nxtSlot = slot;
    nxtBit  = bitIdx;
    doLoad  = 1'b0;
    if (restart) begin
      nxtBit = '0;
      if (commit && pend[2]) begin
        nxtSlot = SLOT_IDLE;
      end else begin
        nxtSlot = startSlot;
        doLoad  = 1'b1;
      end
    end else if (dspWrap) begin
      nxtBit  = '0;
      nxtSlot = slot_e'(slot + 2'd1);
      doLoad  = (slot != SLOT_RIGHT);
    end else if (slot != SLOT_IDLE && bitIdx != LAST_BIT) begin
      nxtBit = bitIdx + 1'b1;
    end
  end

  always_comb begin
    strb.sample  = rise && inWord;
    strb.deliver = rise && lastOfWord;
    strb.rxSlot  = slot;
    strb.load    = rise && doLoad;
    strb.txSlot  = nxtSlot;
    strb.txWc    = newWc;
    strb.launch  = fall;
    strb.active  = inWord;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bitClkQ   <= 1'b0;
      wsPrev    <= 1'b0;
      slot      <= SLOT_IDLE;
      bitIdx    <= '0;
      head      <= '0;
      pend      <= '0;
      pendValid <= 1'b0;
      cfgI2s    <= 1'b0;
      cfgWc     <= 2'd0;
    end else begin
      bitClkQ <= bitClk;
      if (rise) begin
        wsPrev <= wordClk;
        slot   <= nxtSlot;
        bitIdx <= nxtBit;
        if (!cfgI2s && slot == SLOT_CTRL && bitIdx < CW'(3))
          head <= {head[1:0], sdIn};
        if (commit) begin
          cfgI2s    <= pend[2];
          cfgWc     <= pend[1:0];
          pendValid <= 1'b0;
        end
        if (lastOfWord && !cfgI2s && slot == SLOT_CTRL) begin
          pend      <= head;
          pendValid <= 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/audio_port_datapath.sv
module audio_port_datapath
  import audio_port_pkg::*;
#(
  parameter int MAX_W = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sdIn,
  input  strobe_t          strb,
  input  logic [MAX_W-1:0] statusIn,
  input  logic [MAX_W-1:0] adcLeftIn,
  input  logic [MAX_W-1:0] adcRightIn,
  output logic             sdOut,
  output logic [MAX_W-1:0] rxWord,
  output logic             rxValid,
  output logic [1:0]       rxSlot
);
  logic [MAX_W-1:0] rxSh, rxNext, txSh, txSrc, txAligned;
  int unsigned      padBits;

  assign rxNext = {rxSh[MAX_W-2:0], sdIn};

  always_comb begin
    case (strb.txSlot)
      SLOT_CTRL: txSrc = statusIn;
      SLOT_LEFT: txSrc = adcLeftIn;
      default:   txSrc = adcRightIn;
    endcase
  end

  // Left-align the outbound word so the MSB always leaves from the top bit.
  assign padBits   = unsigned'(MAX_W) - widthOf(strb.txWc);
  assign txAligned = txSrc << padBits;

  always_ff @(posedge clk) begin
    if (rst) begin
      rxSh    <= '0;
      rxWord  <= '0;
      rxValid <= 1'b0;
      rxSlot  <= 2'd0;
      txSh    <= '0;
      sdOut   <= 1'b0;
    end else begin
      if (strb.load)        rxSh <= '0;
      else if (strb.sample) rxSh <= rxNext;

      rxValid <= strb.deliver;
      if (strb.deliver) begin
        rxWord <= rxNext;
        rxSlot <= strb.rxSlot;
      end

      if (strb.load)                       txSh <= txAligned;
      else if (strb.launch && strb.active) txSh <= txSh << 1;

      if (strb.launch) sdOut <= strb.active ? txSh[MAX_W-1] : 1'b0;
    end
  end

endmodule

// File: rtl/audio_serial_port.sv
module audio_serial_port
  import audio_port_pkg::*;
#(
  parameter int SLOT_BITS = 32,
  parameter int MAX_W     = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bitClk,
  input  logic             wordClk,
  input  logic             sdIn,
  output logic             sdOut,
  input  logic [MAX_W-1:0] statusIn,
  input  logic [MAX_W-1:0] adcLeftIn,
  input  logic [MAX_W-1:0] adcRightIn,
  output logic [MAX_W-1:0] rxWord,
  output logic             rxValid,
  output logic [1:0]       rxSlot,
  output logic             cfgI2s,
  output logic [1:0]       cfgWidth
);
  strobe_t strb;

  audio_port_ctrl #(.SLOT_BITS(SLOT_BITS)) u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .bitClk  (bitClk),
    .wordClk (wordClk),
    .sdIn    (sdIn),
    .strb    (strb),
    .cfgI2s  (cfgI2s),
    .cfgWc   (cfgWidth)
  );

  audio_port_datapath #(.MAX_W(MAX_W)) u_dp (
    .clk        (clk),
    .rst        (rst),
    .sdIn       (sdIn),
    .strb       (strb),
    .statusIn   (statusIn),
    .adcLeftIn  (adcLeftIn),
    .adcRightIn (adcRightIn),
    .sdOut      (sdOut),
    .rxWord     (rxWord),
    .rxValid    (rxValid),
    .rxSlot     (rxSlot)
  );

endmodule

// File: rtl/audio_serial_port_chk.sv
module audio_serial_port_chk (
  input logic       clk,
  input logic       rst,
  input logic       bitClk,
  input logic       wordClk,
  input logic       sdOut,
  input logic       rxValid,
  input logic [1:0] rxSlot,
  input logic       cfgI2s,
  input logic [1:0] cfgWidth
);

  AST_RESET_STATE: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (!cfgI2s && cfgWidth == 2'd0 && !sdOut && !rxValid)); // R1

  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (rst)
    rxValid |=> !rxValid); // R5

  AST_SAMPLE_ON_RISE: assert property (@(posedge clk) disable iff (rst)
    rxValid |-> ($past(bitClk) && !$past(bitClk, 2))); // R9

  AST_LAUNCH_ON_FALL: assert property (@(posedge clk) disable iff (rst)
    (sdOut != $past(sdOut)) |-> (!$past(bitClk) && $past(bitClk, 2))); // R9

  AST_NO_IDLE_DELIVERY: assert property (@(posedge clk) disable iff (rst)
    rxValid |-> (rxSlot != 2'd3)); // R2

  AST_I2S_NO_CTRL: assert property (@(posedge clk) disable iff (rst)
    (rxValid && cfgI2s && $past(cfgI2s)) |-> (rxSlot != 2'd0)); // R8

  AST_CFG_AT_SYNC: assert property (@(posedge clk) disable iff (rst)
    (cfgI2s != $past(cfgI2s) || cfgWidth != $past(cfgWidth)) |->
      ($past(wordClk) && !$past(cfgI2s) && $past(bitClk) && !$past(bitClk, 2))); // R7

  AST_I2S_STICKY: assert property (@(posedge clk) disable iff (rst)
    cfgI2s |=> cfgI2s); // R7

endmodule

bind audio_serial_port audio_serial_port_chk u_chk (.*);

// File: tb/sim_audio_serial_port.sv
module sim_audio_serial_port;
  localparam int SLOT_BITS = 32;
  localparam int MAX_W     = 24;

  logic clk = 1'b0;
  always #4 clk = ~clk;   // 125 MHz

  logic             rst = 1'b1, bitClk = 1'b0, wordClk = 1'b0, sdIn = 1'b0;
  logic [MAX_W-1:0] statusIn = '0, adcLeftIn = '0, adcRightIn = '0;
  logic             sdOut, rxValid, cfgI2s;
  logic [MAX_W-1:0] rxWord;
  logic [1:0]       rxSlot, cfgWidth;

  audio_serial_port #(.SLOT_BITS(SLOT_BITS), .MAX_W(MAX_W)) u0 (
    .clk(clk), .rst(rst), .bitClk(bitClk), .wordClk(wordClk), .sdIn(sdIn),
    .sdOut(sdOut), .statusIn(statusIn), .adcLeftIn(adcLeftIn), .adcRightIn(adcRightIn),
    .rxWord(rxWord), .rxValid(rxValid), .rxSlot(rxSlot), .cfgI2s(cfgI2s), .cfgWidth(cfgWidth)
  );

  int vectors = 0, miscompares = 0;

  // Reference model state.
  logic             expSd = 1'b0, expValid = 1'b0, expI2s = 1'b0;
  logic [MAX_W-1:0] expWord = '0;
  logic [1:0]       expSlot = 2'd0, expWc = 2'd0;
  logic [2:0]       pendCfg = 3'd0;
  bit               pendSet = 1'b0;
  string            curReq = "R1";

  function automatic int wOf(input logic [1:0] c);
    return (c == 2'd3) ? 24 : 16 + 2 * int'(c);
  endfunction

  task automatic tick();
    @(negedge clk);
    vectors++;
    if (sdOut !== expSd) begin
      miscompares++;
      $display("FAIL %s R9 sdOut got %b expected %b at %0t", curReq, sdOut, expSd, $time);
    end
    if (rxValid !== expValid) begin
      miscompares++;
      $display("FAIL R5 rxValid got %b expected %b at %0t", rxValid, expValid, $time);
    end
    if (rxWord !== expWord || (expValid && rxSlot !== expSlot)) begin
      miscompares++;
      $display("FAIL %s rxWord/rxSlot got %h/%0d expected %h/%0d at %0t",
               curReq, rxWord, rxSlot, expWord, expSlot, $time);
    end
    if (cfgI2s !== expI2s || cfgWidth !== expWc) begin
      miscompares++;
      $display("FAIL R7 config got %b/%b expected %b/%b at %0t",
               cfgI2s, cfgWidth, expI2s, expWc, $time);
    end
    expValid = 1'b0;
  endtask

  // One bit period: fall (launch) then rise (sample), four system clocks.
  task automatic bitStep(input logic din, input logic ws, input logic launch,
                         input logic dlv, input logic [MAX_W-1:0] word, input logic [1:0] slot);
    tick();
    bitClk = 1'b0; sdIn = din; wordClk = ws; expSd = launch;
    tick();
    tick();
    bitClk = 1'b1;
    if (dlv) begin expValid = 1'b1; expWord = word; expSlot = slot; end
    if (!expI2s && ws && pendSet) begin   // R7: commit at frame sync
      expI2s = pendCfg[2]; expWc = pendCfg[1:0]; pendSet = 1'b0;
    end
    tick();
  endtask

  task automatic dspFrame(input logic [MAX_W-1:0] ctl, input logic [MAX_W-1:0] dl,
                          input logic [MAX_W-1:0] dr, input logic [MAX_W-1:0] st,
                          input logic [MAX_W-1:0] al, input logic [MAX_W-1:0] ar);
    int w;
    logic [MAX_W-1:0] m;
    logic [MAX_W-1:0] inW [3];
    logic [MAX_W-1:0] outW [3];
    statusIn = st; adcLeftIn = al; adcRightIn = ar;
    bitStep(1'b0, 1'b1, 1'b0, 1'b0, '0, 2'd0);   // frame sync
    w = wOf(expWc);
    m = (MAX_W'(1) << w) - MAX_W'(1);
    inW  = '{ctl, dl, dr};
    outW = '{st, al, ar};
    for (int s = 0; s < 3; s++) begin
      for (int b = 0; b < SLOT_BITS; b++) begin
        // R4: positions past W carry junk ones inbound and expect zero outbound
        bitStep((b < w) ? inW[s][w-1-b] : 1'b1, 1'b0,
                (b < w) ? outW[s][w-1-b] : 1'b0,
                (b == w - 1), inW[s] & m, 2'(s));
      end
    end
    pendCfg = {ctl[w-1], ctl[w-2], ctl[w-3]};
    pendSet = 1'b1;
  endtask

  task automatic i2sWord(input logic ch, input int len, input logic [MAX_W-1:0] inW,
                         input logic [MAX_W-1:0] outW, input logic nextCh);
    int w;
    logic [MAX_W-1:0] m;
    w = wOf(expWc);
    m = (MAX_W'(1) << w) - MAX_W'(1);
    for (int b = 0; b < len; b++) begin
      bitStep((b < w) ? inW[w-1-b] : 1'b1, (b == len - 1) ? nextCh : ch,
              (b < w) ? outW[w-1-b] : 1'b0, (b == w - 1), inW & m,
              ch ? 2'd2 : 2'd1);
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog expired at %0t", $time);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    curReq = "R1";
    repeat (4) tick();
    rst = 1'b0;
    repeat (3) tick();          // R1 reset state held

    curReq = "R2 R3 R4";        // 16-bit frame, control keeps DSP/16
    dspFrame(24'h001A5C, 24'hFF9E37, 24'h00C001, 24'h00F0A5, 24'hAB8421, 24'h0076E9);

    curReq = "R10";             // idle after the right slot
    for (int i = 0; i < 4; i++) bitStep(1'b1, 1'b0, 1'b0, 1'b0, '0, 2'd0);

    curReq = "R2 R3 R5";        // control 0,11 -> 24-bit pending
    dspFrame(24'h006B21, 24'h00FFFF, 24'h000000, 24'h005555, 24'h008001, 24'h007FFE);

    curReq = "R6 24-bit";       // control 0,10 -> 20-bit pending
    dspFrame(24'h4C3D2E, 24'h812345, 24'hFEDCBA, 24'hA5A5A5, 24'h13579B, 24'hF00F0F);

    curReq = "R6 20-bit";       // control 0,01 -> 18-bit pending
    dspFrame(24'h029F10, 24'h0ABCDE, 24'hF80001, 24'h0C3C3C, 24'h3FFFFF, 24'h080000);

    curReq = "R6 18-bit";       // control 1,00 -> I2S 16-bit pending
    dspFrame(24'h020ABC, 24'h02F0F1, 24'h01234F, 24'h03AAAA, 24'h020001, 24'h00FFFE);

    curReq = "R7";              // frame sync commits I2S, port goes idle
    bitStep(1'b0, 1'b1, 1'b0, 1'b0, '0, 2'd0);

    curReq = "R8";
    adcLeftIn = 24'h00C3A5; adcRightIn = 24'h005A3C;
    bitStep(1'b1, 1'b0, 1'b0, 1'b0, '0, 2'd0);   // word clock falls: left begins
    i2sWord(1'b0, 32, 24'h00BEEF, adcLeftIn, 1'b1);
    i2sWord(1'b1, 32, 24'h001234, adcRightIn, 1'b0);
    i2sWord(1'b0, 16, 24'h00F00D, adcLeftIn, 1'b1);
    i2sWord(1'b1, 20, 24'h00ABCD, adcRightIn, 1'b0);
    curReq = "R8 short";
    i2sWord(1'b0, 8, 24'h0000FF, adcLeftIn, 1'b1);
    curReq = "R8 R4";
    i2sWord(1'b1, 24, 24'h007E81, adcRightIn, 1'b1);
    for (int i = 0; i < 3; i++) bitStep(1'b1, 1'b1, 1'b0, 1'b0, '0, 2'd0);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule